// File: doc/BRIEF.md
# Palette DAC Host Register Interface

This block is the processor-facing side of a VGA-style colour palette. A byte-wide I/O bus (address, read strobe, write strobe, write data, registered read data) reaches a 256-entry colour table. Each entry holds three 6-bit components: red, green and blue. Software picks an entry by writing a read-direction or a write-direction index. It then moves colour bytes through a single data port, three accesses per entry. The component counter and the entry index advance on their own.

A direction flag records which index was written last. While that flag is not in read mode, reads of the data port return a fixed filler byte and leave the read cursor alone. A pixel mask register is kept as well. A separate combinational lookup port masks an 8-bit pixel value and returns the 18-bit colour of the selected entry. The lookup port lets the table contents be inspected directly.

Top module: `pal_dac_regs`

## Requirements
- R1: After reset the direction flag is 2'b01, the pixel mask is 0xFF, and both entry indices and both component counters are zero. The first data write therefore lands in red of entry 0.
- R2: A write to address 0x3C7 loads the read index from the data byte, clears the read component counter, and sets the direction flag to 2'b11 (read mode).
- R3: A write to address 0x3C8 loads the write index from the data byte, clears the write component counter, and sets the direction flag to 2'b00.
- R4: A read of address 0x3C7 returns the direction flag in bits [1:0], with zeros above.
- R5: Successive writes to 0x3C9 store bits [5:0] of the byte into red, then green, then blue of the entry at the write index. After blue, the counter returns to red and the index increments, wrapping from 0xFF to 0x00.
- R6: In read mode, successive reads of 0x3C9 return red, green, then blue of the entry at the read index, zero-extended to 8 bits. After blue, the index increments and wraps from 0xFF to 0x00.
- R7: When the direction flag is not 2'b11, a read of 0x3C9 returns 0x3F and leaves the direction flag unchanged.
- R8: A write to 0x3C6 stores the full byte as the pixel mask, and a read of 0x3C6 returns it.
- R9: A read of any address other than 0x3C6, 0x3C7 or 0x3C9 returns 0xFF. A write to an address outside 0x3C6 to 0x3C9 changes no state.
- R10: The lookup output is the colour of entry (pixel AND mask), with red in bits [17:12], green in [11:6] and blue in [5:0]. It follows the pixel input and the table contents without a clock.
- R11: Read data appears on the clock edge that samples the read strobe. It holds until the next read.
- R12: Data-port writes update the table in any direction-flag state and do not change the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lkp_pixel | input | 8 | Pixel value for the lookup port |
| lkp_color | output | 18 | Colour of the masked entry {red, green, blue} |

## Verification
The hardest cases are the two index wraps from 0xFF to 0x00 on the read and write sides. Each one needs the counter to finish a full red-green-blue group at the last entry. The bench first fills the whole table with 768 data writes, which makes the write index wrap, and then writes three more bytes to entry 0. It then loads the read index with 0xFE and reads nine times, so reads cross the same wrap. Random traffic afterwards mixes index loads, mask changes and data accesses in both directions. This catches filler reads and counter carries out of order.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  localparam int unsigned COMP_N = 3;

  typedef enum logic [1:0] {
    DST_WRITE = 2'b00,
    DST_RESET = 2'b01,
    DST_READ  = 2'b11
  } dac_state_e;

  localparam logic [15:0] P_MASK = 16'h03C6;
  localparam logic [15:0] P_RIDX = 16'h03C7;
  localparam logic [15:0] P_WIDX = 16'h03C8;
  localparam logic [15:0] P_DATA = 16'h03C9;

  localparam logic [7:0] FILL_DATA = 8'h3F;
  localparam logic [7:0] FILL_OPEN = 8'hFF;
endpackage

// File: rtl/pal_dac_cursor.sv
module pal_dac_cursor #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       cnt
);
  localparam logic [1:0] LAST = 2'(pal_dac_pkg::COMP_N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      cnt <= '0;
    end else if (load) begin
      idx <= load_val;
      cnt <= '0;
    end else if (step) begin
      if (cnt == LAST) begin
        cnt <= '0;
        idx <= idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5 / R6: counter never leaves red..blue
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

  // R5 / R6: finishing blue carries into the index
  a_r6_carry: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt == LAST) |=> (cnt == 2'd0 && idx == IDX_W'($past(idx) + 1'b1)));

  // R2 / R3: loading restarts at red
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == 2'd0 && idx == $past(load_val)));
endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 6
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [IDX_W-1:0]             waddr,
  input  logic [1:0]                   wcomp,
  input  logic [COMP_W-1:0]            wdata,
  input  logic [IDX_W-1:0]             raddr,
  input  logic [1:0]                   rcomp,
  output logic [COMP_W-1:0]            rdata,
  input  logic [IDX_W-1:0]             laddr,
  output logic [pal_dac_pkg::COMP_N*COMP_W-1:0] lcolor
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned NC    = pal_dac_pkg::COMP_N;

  logic [NC-1:0][COMP_W-1:0] rd_vec;

  for (genvar c = 0; c < NC; c++) begin : g_comp
    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wcomp == 2'(c)) mem[waddr] <= wdata;
    end

    assign rd_vec[c] = mem[raddr];
    assign lcolor[(NC-1-c)*COMP_W +: COMP_W] = mem[laddr];
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NC; c++) begin
      if (rcomp == 2'(c)) rdata = rd_vec[c];
    end
  end
endmodule

// File: rtl/pal_dac_regs.sv
module pal_dac_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [IDX_W-1:0]      lkp_pixel,
  output logic [3*COMP_W-1:0]   lkp_color
);
  import pal_dac_pkg::*;

  localparam logic [BUS_W-1:0] FILLER = BUS_W'(FILL_DATA);
  localparam logic [BUS_W-1:0] OPEN   = BUS_W'(FILL_OPEN);

  logic hit_mask, hit_ridx, hit_widx, hit_data;
  assign hit_mask = (bus_addr == ADDR_W'(P_MASK));
  assign hit_ridx = (bus_addr == ADDR_W'(P_RIDX));
  assign hit_widx = (bus_addr == ADDR_W'(P_WIDX));
  assign hit_data = (bus_addr == ADDR_W'(P_DATA));

  logic wr_mask, wr_ridx, wr_widx, wr_data, rd_data;
  assign wr_mask = bus_wr && hit_mask;
  assign wr_ridx = bus_wr && hit_ridx;
  assign wr_widx = bus_wr && hit_widx;
  assign wr_data = bus_wr && hit_data;
  assign rd_data = bus_rd && hit_data;

  dac_state_e       dstate;
  logic [IDX_W-1:0] pix_mask;
  logic             rd_live;
  assign rd_live = rd_data && (dstate == DST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      dstate   <= DST_RESET;
      pix_mask <= '1;
    end else begin
      if (wr_ridx)      dstate <= DST_READ;
      else if (wr_widx) dstate <= DST_WRITE;
      if (wr_mask) pix_mask <= bus_wdata[IDX_W-1:0];
    end
  end

  logic [IDX_W-1:0] ridx, widx;
  logic [1:0]       rcnt, wcnt;

  pal_dac_cursor #(.IDX_W(IDX_W)) i_rcur (
    .clk(clk), .rst(rst), .load(wr_ridx), .load_val(bus_wdata[IDX_W-1:0]),
    .step(rd_live), .idx(ridx), .cnt(rcnt)
  );

  pal_dac_cursor #(.IDX_W(IDX_W)) i_wcur (
    .clk(clk), .rst(rst), .load(wr_widx), .load_val(bus_wdata[IDX_W-1:0]),
    .step(wr_data), .idx(widx), .cnt(wcnt)
  );

  logic [COMP_W-1:0] comp_rd;

  pal_dac_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) i_store (
    .clk(clk), .we(wr_data), .waddr(widx), .wcomp(wcnt),
    .wdata(bus_wdata[COMP_W-1:0]), .raddr(ridx), .rcomp(rcnt), .rdata(comp_rd),
    .laddr(lkp_pixel & pix_mask), .lcolor(lkp_color)
  );

  logic [BUS_W-1:0] rd_next;
  always_comb begin
    if (hit_mask)      rd_next = BUS_W'(pix_mask);
    else if (hit_ridx) rd_next = BUS_W'(dstate);
    else if (hit_data) rd_next = (dstate == DST_READ) ? BUS_W'(comp_rd) : FILLER;
    else               rd_next = OPEN;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R1: flag only ever holds one of the three defined codes
  a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
    dstate inside {DST_WRITE, DST_RESET, DST_READ});

  // R2: read-index load enters read mode
  a_r2_enter_read: assert property (@(posedge clk) disable iff (rst)
    wr_ridx |=> dstate == DST_READ);

  // R3: write-index load leaves read mode
  a_r3_enter_write: assert property (@(posedge clk) disable iff (rst)
    wr_widx |=> dstate == DST_WRITE);

  // R7: data read outside read mode yields filler and holds the cursor
  a_r7_filler: assert property (@(posedge clk) disable iff (rst)
    (rd_data && dstate != DST_READ) |=> bus_rdata == FILLER);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data && dstate != DST_READ && !bus_wr) |=> ($stable(ridx) && $stable(rcnt)));

  // R11: read data is stable between reads
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R12: data writes leave the flag alone
  a_r12_flag_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !bus_rd) |=> $stable(dstate));
endmodule

// File: tb/test_pal_dac_regs.sv
module test_pal_dac_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  lkp_pixel;
  logic [17:0] lkp_color;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pal_dac_regs i_pal_dac_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lkp_pixel(lkp_pixel), .lkp_color(lkp_color)
  );

  // reference model
  logic [1:0]  m_state;
  logic [7:0]  m_mask, m_ridx, m_widx;
  int          m_rcnt, m_wcnt;
  logic [17:0] m_pal [256];

  function automatic logic [7:0] comp_of(logic [17:0] e, int c);
    case (c)
      0:       return {2'b00, e[17:12]};
      1:       return {2'b00, e[11:6]};
      default: return {2'b00, e[5:0]};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    case (a)
      16'h03C6: m_mask = d;
      16'h03C7: begin m_ridx = d; m_rcnt = 0; m_state = 2'b11; end
      16'h03C8: begin m_widx = d; m_wcnt = 0; m_state = 2'b00; end
      16'h03C9: begin
        case (m_wcnt)
          0:       m_pal[m_widx][17:12] = d[5:0];
          1:       m_pal[m_widx][11:6]  = d[5:0];
          default: m_pal[m_widx][5:0]   = d[5:0];
        endcase
        m_wcnt++;
        if (m_wcnt == 3) begin m_wcnt = 0; m_widx++; end
      end
      default: ;
    endcase
  endtask

  task automatic model_rd(logic [15:0] a, output logic [7:0] e);
    case (a)
      16'h03C6: e = m_mask;
      16'h03C7: e = {6'b0, m_state};
      16'h03C9: begin
        if (m_state == 2'b11) begin
          e = comp_of(m_pal[m_ridx], m_rcnt);
          m_rcnt++;
          if (m_rcnt == 3) begin m_rcnt = 0; m_ridx++; end
        end else e = 8'h3F;
      end
      default: e = 8'hFF;
    endcase
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_read_chk(string req, logic [15:0] a);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    model_rd(a, e);
    chk(req, bus_rdata, e);
  endtask

  task automatic look_chk(string req, logic [7:0] p);
    @(negedge clk);
    lkp_pixel = p;
    #1;
    chk(req, lkp_color, m_pal[p & m_mask]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h1234_5EED));
    rst = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; lkp_pixel = '0;
    m_state = 2'b01; m_mask = 8'hFF; m_ridx = 0; m_widx = 0; m_rcnt = 0; m_wcnt = 0;
    for (int i = 0; i < 256; i++) m_pal[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R4: reset flag and mask
    bus_read_chk("R1_R4 reset flag", 16'h03C7);
    bus_read_chk("R1_R8 reset mask", 16'h03C6);
    // R7: not in read mode after reset
    bus_read_chk("R7 filler after reset", 16'h03C9);
    bus_read_chk("R7 flag unchanged", 16'h03C7);

    // R1 / R5: fill whole table from reset write cursor, wrapping the index
    for (int i = 0; i < 768; i++) bus_write(16'h03C9, 8'($urandom));
    for (int i = 0; i < 256; i++) look_chk("R5_R10 filled entry", 8'(i));
    for (int i = 0; i < 3; i++) bus_write(16'h03C9, 8'($urandom));
    look_chk("R5 write index wrap to entry 0", 8'h00);
    look_chk("R5 entry 1 untouched", 8'h01);

    // R2 / R6: read mode and read-side wrap
    bus_write(16'h03C7, 8'hFE);
    bus_read_chk("R2_R4 read mode flag", 16'h03C7);
    for (int i = 0; i < 9; i++) bus_read_chk("R6 read sequence across wrap", 16'h03C9);

    // R11: data held with no read
    held = bus_rdata;
    repeat (4) @(negedge clk);
    chk("R11 read data hold", bus_rdata, held);

    // R12: data write in read mode lands in table, flag kept
    bus_write(16'h03C8, 8'h40);
    bus_write(16'h03C7, 8'h40);
    bus_write(16'h03C9, 8'h2A);
    bus_read_chk("R12 flag kept after data write", 16'h03C7);
    look_chk("R12 data write in read mode", 8'h40);

    // R3 / R7
    bus_write(16'h03C8, 8'h10);
    bus_read_chk("R3_R4 write mode flag", 16'h03C7);
    bus_read_chk("R7 filler in write mode", 16'h03C9);
    bus_read_chk("R7 flag unchanged", 16'h03C7);

    // R9: undecoded ports
    bus_write(16'h03C5, 8'h00);
    bus_write(16'h03CA, 8'h11);
    bus_write(16'h0000, 8'h22);
    bus_read_chk("R9 open read 3C5", 16'h03C5);
    bus_read_chk("R9 open read 3C8", 16'h03C8);
    bus_read_chk("R9 mask untouched", 16'h03C6);
    bus_read_chk("R9 flag untouched", 16'h03C7);
    bus_write(16'h03C9, 8'h3C);
    look_chk("R9 write cursor untouched", 8'h10);

    // R8 / R10: masking
    bus_write(16'h03C6, 8'h0F);
    bus_read_chk("R8 mask readback", 16'h03C6);
    look_chk("R10 masked lookup", 8'hF3);
    look_chk("R10 masked lookup high", 8'hAF);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom_range(0, 9));
      a = 16'h03C5 + 16'($urandom_range(0, 5));
      case (op)
        0, 1, 2: bus_write(16'h03C9, 8'($urandom));
        3:       bus_write(a, 8'($urandom));
        4:       bus_write(16'h03C7, 8'($urandom));
        5, 6:    bus_read_chk("R6_R7 random data read", 16'h03C9);
        7:       bus_read_chk("R4_R8_R9 random read", a);
        default: look_chk("R10 random lookup", 8'($urandom));
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule